// File: doc/BRIEF.md
# Freezable Data-Path Capture Buffer

This block watches one data link without taking part in it. Every cycle that the link carries a valid word, the block writes the word into a circular store and advances a write pointer. Nothing flows back into the link, so the data path runs the same whether the block is present or not. The store therefore always holds the most recent words that crossed the link.

An error stops the recording, so the words that led up to the fault stay in the store. The error can be flagged on this board or arrive on a freeze line shared by every board in the system. A programmable number of further words is still taken after the trigger, so the store also shows what followed the fault. A freeze raised on this board is driven out on the shared line, which stops the neighbouring buffers at the same event. Each freeze also sends a short fixed-length pulse to a test pin, where an external instrument can trigger on it.

A host reads the store by address at any time. Reads do not depend on the link traffic and have no effect on it. The host also sees the write pointer and a flag that shows the store has filled at least once. A single release command clears the freeze, and recording then continues from the pointer where it stopped.

Top module: `spy_buffer`

## Requirements
- R1: After a synchronous reset, wr_ptr is 0 and wrapped, frozen, halted, freeze_out and err_trig are all 0.
- R2: While recording (frozen=0, or frozen=1 with halted=0), each cycle with in_valid=1 stores in_data at address wr_ptr, and wr_ptr grows by 1 on the next cycle. A cycle with in_valid=0 leaves wr_ptr unchanged.
- R3: wr_ptr steps from DEPTH-1 (1023 by default) back to 0. On that step, wrapped becomes 1 and stays 1 until reset.
- R4: local_err=1 or freeze_in=1 while frozen=0 is a trigger. A valid word in the trigger cycle is still stored, and frozen reads 1 from the next cycle on. Exactly post_len further valid words are then stored, after which halted reads 1. With post_len=0, halted reads 1 in the cycle right after the trigger.
- R5: While halted=1, valid input words change neither wr_ptr nor the store contents.
- R6: host_rd_data shows the word stored at host_addr one cycle after host_addr is applied. A read never changes wr_ptr, frozen or halted.
- R7: host_unfreeze=1 while frozen=1 clears frozen and halted on the next cycle. The next valid word is then stored at the current wr_ptr.
- R8: err_trig is 1 for exactly 4 consecutive cycles, starting the cycle after a trigger. local_err or freeze_in raised while frozen=1 produces no pulse.
- R9: freeze_out goes to 1 the cycle after a trigger caused by local_err and stays at 1 until the release. A trigger that comes only from freeze_in leaves freeze_out at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Link word valid |
| in_data | input | DATA_W | Link word |
| local_err | input | 1 | Error flagged on this board |
| freeze_in | input | 1 | Shared system freeze request |
| post_len | input | POST_W | Number of words recorded after a trigger |
| host_unfreeze | input | 1 | Host release command |
| host_addr | input | ADDR_W | Host read address |
| host_rd_data | output | DATA_W | Word read at host_addr, one cycle later |
| wr_ptr | output | ADDR_W | Next write address |
| wrapped | output | 1 | Store has filled at least once |
| frozen | output | 1 | A trigger has been taken and not yet released |
| halted | output | 1 | Recording has stopped |
| freeze_out | output | 1 | Local freeze driven onto the shared line |
| err_trig | output | 1 | Test pulse for external equipment |

## Verification
The bench goes after the post-trigger count. A count that is off by one stores one word too many or too few before halted rises, and this shows up in the pointer and in the data read back. It checks that triggers arriving during a freeze do nothing. A design that re-arms would stretch the test pulse or restart the post-trigger count. It checks that a freeze coming only from the shared line is not echoed back onto it, since an echo would lock every board in the system. The bench also runs the pointer through its wrap. A wrong wrap flag would be set one word early or would clear itself on a later word.

// File: rtl/spy_pkg.sv
package spy_pkg;

    // capture state machine
    typedef enum logic [1:0] {
        CAP_RUN  = 2'd0,
        CAP_POST = 2'd1,
        CAP_HALT = 2'd2
    } cap_state_e;

    // events handed from the capture control to the trigger output stage
    typedef struct packed {
        logic fire;        // trigger accepted this cycle
        logic local_src;   // trigger included a local error
        logic release_ev;  // host release accepted this cycle
    } trig_evt_t;

    function automatic logic is_recording(input cap_state_e st);
        return (st == CAP_RUN) || (st == CAP_POST);
    endfunction

endpackage

// File: rtl/spy_store.sv
module spy_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= cells[raddr];
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/spy_capture_ctrl.sv
module spy_capture_ctrl
    import spy_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int POST_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              local_err,
    input  logic              freeze_in,
    input  logic [POST_W-1:0] post_len,
    input  logic              host_unfreeze,
    output logic              we,
    output logic [ADDR_W-1:0] ptr,
    output logic              wrapped,
    output logic              frozen,
    output logic              halted,
    output trig_evt_t         evt
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    cap_state_e        state_q, state_d;
    logic [POST_W-1:0] remain_q, remain_d;
    logic [ADDR_W-1:0] ptr_q;
    logic              wrap_q;
    logic              trig_req;

    assign trig_req = local_err | freeze_in;
    assign we       = in_valid & is_recording(state_q);

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        evt      = '0;
        unique case (state_q)
            CAP_RUN: begin
                if (trig_req) begin
                    evt.fire      = 1'b1;
                    evt.local_src = local_err;
                    remain_d      = post_len;
                    state_d       = (post_len == '0) ? CAP_HALT : CAP_POST;
                end
            end
            CAP_POST: begin
                if (host_unfreeze) begin
                    evt.release_ev = 1'b1;
                    state_d        = CAP_RUN;
                end else if (in_valid) begin
                    remain_d = remain_q - 1'b1;
                    if (remain_q == POST_W'(1)) begin
                        state_d = CAP_HALT;
                    end
                end
            end
            CAP_HALT: begin
                if (host_unfreeze) begin
                    evt.release_ev = 1'b1;
                    state_d        = CAP_RUN;
                end
            end
            default: state_d = CAP_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CAP_RUN;
            remain_q <= '0;
            ptr_q    <= '0;
            wrap_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            if (we) begin
                if (ptr_q == LAST_ADDR) begin
                    ptr_q  <= '0;
                    wrap_q <= 1'b1;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    assign ptr     = ptr_q;
    assign wrapped = wrap_q;
    assign frozen  = (state_q != CAP_RUN);
    assign halted  = (state_q == CAP_HALT);

    // R2: a recorded word moves the pointer on by one (modulo depth)
    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !halted) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));

    // R3: once filled, the wrap flag never drops
    assert_wrap_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        wrap_q |=> wrap_q);

    // R4: a zero post-trigger length halts right after the trigger
    assert_zero_post_R4: assert property (@(posedge clk) disable iff (rst)
        (!frozen && trig_req && post_len == '0) |=> halted);

    // R5: while halted without a release the pointer holds
    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (halted && !host_unfreeze) |=> $stable(ptr_q));

    // R7: a release while frozen returns to recording
    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        (frozen && host_unfreeze) |=> !frozen);

endmodule

// File: rtl/spy_trig_out.sv
module spy_trig_out
    import spy_pkg::*;
#(
    parameter int PULSE_LEN = 4,
    localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  trig_evt_t evt,
    output logic      err_trig,
    output logic      freeze_out
);

    logic [CNT_W-1:0] cnt_q;
    logic             glob_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            glob_q <= 1'b0;
        end else begin
            if (evt.fire) begin
                cnt_q <= CNT_W'(PULSE_LEN);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (evt.fire && evt.local_src) begin
                glob_q <= 1'b1;
            end else if (evt.release_ev) begin
                glob_q <= 1'b0;
            end
        end
    end

    assign err_trig   = (cnt_q != '0);
    assign freeze_out = glob_q;

    // checker: cycles since the last trigger event
    logic [7:0] since_fire;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_fire <= '0;
        end else if (evt.fire) begin
            since_fire <= 8'd1;
        end else if (since_fire != 8'hFF) begin
            since_fire <= since_fire + 1'b1;
        end
    end

    // R8: the test pulse ends exactly PULSE_LEN cycles after its trigger
    assert_pulse_len_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(err_trig) |-> (since_fire == 8'(PULSE_LEN + 1)));

    // R8: the pulse starts the cycle after a trigger
    assert_pulse_start_R8: assert property (@(posedge clk) disable iff (rst)
        evt.fire |=> err_trig);

    // R9: a local trigger is driven out on the shared line
    assert_glob_local_R9: assert property (@(posedge clk) disable iff (rst)
        (evt.fire && evt.local_src) |=> freeze_out);

endmodule

// File: rtl/spy_buffer.sv
module spy_buffer
    import spy_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 1024,
    parameter int POST_W    = 8,
    parameter int PULSE_LEN = 4,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              local_err,
    input  logic              freeze_in,
    input  logic [POST_W-1:0] post_len,
    input  logic              host_unfreeze,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_rd_data,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              wrapped,
    output logic              frozen,
    output logic              halted,
    output logic              freeze_out,
    output logic              err_trig
);

    logic      we;
    trig_evt_t evt;

    spy_capture_ctrl #(
        .DEPTH  (DEPTH),
        .POST_W (POST_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .local_err     (local_err),
        .freeze_in     (freeze_in),
        .post_len      (post_len),
        .host_unfreeze (host_unfreeze),
        .we            (we),
        .ptr           (wr_ptr),
        .wrapped       (wrapped),
        .frozen        (frozen),
        .halted        (halted),
        .evt           (evt)
    );

    spy_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (wr_ptr),
        .wdata (in_data),
        .raddr (host_addr),
        .rdata (host_rd_data)
    );

    spy_trig_out #(
        .PULSE_LEN (PULSE_LEN)
    ) u_trig (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .err_trig   (err_trig),
        .freeze_out (freeze_out)
    );

endmodule

// File: tb/test_spy_buffer.sv
module test_spy_buffer;

    localparam int DATA_W = 16;
    localparam int DEPTH  = 1024;
    localparam int ADDR_W = 10;
    localparam int POST_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              local_err = 1'b0;
    logic              freeze_in = 1'b0;
    logic [POST_W-1:0] post_len = '0;
    logic              host_unfreeze = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_rd_data;
    logic [ADDR_W-1:0] wr_ptr;
    logic              wrapped, frozen, halted, freeze_out, err_trig;

    int checks = 0;
    int errors = 0;
    int mptr   = 0;
    int pulses = 0;
    logic [DATA_W-1:0] shadow [DEPTH];

    always #2.5 clk = ~clk;

    spy_buffer i_spy_buffer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .local_err(local_err), .freeze_in(freeze_in), .post_len(post_len),
        .host_unfreeze(host_unfreeze), .host_addr(host_addr),
        .host_rd_data(host_rd_data), .wr_ptr(wr_ptr), .wrapped(wrapped),
        .frozen(frozen), .halted(halted), .freeze_out(freeze_out),
        .err_trig(err_trig)
    );

    // {valid, data}
    localparam logic [16:0] VEC [8] = '{
        {1'b1, 16'hA001}, {1'b0, 16'hDEAD}, {1'b1, 16'h0000}, {1'b1, 16'hFFFF},
        {1'b0, 16'hBEEF}, {1'b1, 16'h5A5A}, {1'b1, 16'h1234}, {1'b0, 16'h7777}
    };

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // record a word the bench expects to be stored
    task automatic push(input logic [DATA_W-1:0] d);
        in_valid = 1'b1;
        in_data  = d;
        step();
        in_valid = 1'b0;
        shadow[mptr] = d;
        mptr = (mptr + 1) % DEPTH;
    endtask

    task automatic read_chk(input string req, input int a);
        host_addr = ADDR_W'(a);
        step();
        chk(req, 32'(host_rd_data), 32'(shadow[a]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: reset state
        chk("R1 wr_ptr", 32'(wr_ptr), 0);
        chk("R1 wrapped", 32'(wrapped), 0);
        chk("R1 frozen", 32'(frozen), 0);
        chk("R1 halted", 32'(halted), 0);
        chk("R1 freeze_out", 32'(freeze_out), 0);
        chk("R1 err_trig", 32'(err_trig), 0);

        // R2: vector table walk
        for (int i = 0; i < 8; i++) begin
            in_valid = VEC[i][16];
            in_data  = VEC[i][15:0];
            step();
            if (VEC[i][16]) begin
                shadow[mptr] = VEC[i][15:0];
                mptr++;
            end
            chk("R2 pointer", 32'(wr_ptr), 32'(mptr));
        end
        in_valid = 1'b0;
        for (int a = 0; a < mptr; a++) read_chk("R2 stored word", a);

        // R4/R8/R9: local trigger with three post words
        post_len  = 8'd3;
        local_err = 1'b1;
        in_valid  = 1'b1;
        in_data   = 16'hC0DE;
        step();
        local_err = 1'b0;
        in_valid  = 1'b0;
        shadow[mptr] = 16'hC0DE;
        mptr++;
        pulses += int'(err_trig);
        chk("R4 frozen after trigger", 32'(frozen), 1);
        chk("R4 not halted yet", 32'(halted), 0);
        chk("R9 freeze_out local", 32'(freeze_out), 1);
        for (int k = 0; k < 3; k++) begin
            local_err = (k == 1);   // R8: ignored while frozen
            push(16'h3000 + 16'(k));
            local_err = 1'b0;
            pulses += int'(err_trig);
            if (k < 2) chk("R4 still recording", 32'(halted), 0);
        end
        chk("R4 halted after post words", 32'(halted), 1);
        chk("R4 pointer after post words", 32'(wr_ptr), 32'(mptr));
        for (int k = 0; k < 2; k++) begin
            in_valid = 1'b1;
            in_data  = 16'hEEEE;
            step();
            pulses += int'(err_trig);
        end
        in_valid = 1'b0;
        chk("R5 pointer held while halted", 32'(wr_ptr), 32'(mptr));
        step();
        pulses += int'(err_trig);
        step();
        pulses += int'(err_trig);
        chk("R8 pulse length", 32'(pulses), 4);

        // R6: reads while halted
        for (int a = mptr - 4; a < mptr; a++) read_chk("R6 read frozen data", a);
        chk("R6 pointer after reads", 32'(wr_ptr), 32'(mptr));
        chk("R6 halted after reads", 32'(halted), 1);

        // R7: release and resume
        host_unfreeze = 1'b1;
        step();
        host_unfreeze = 1'b0;
        chk("R7 frozen cleared", 32'(frozen), 0);
        chk("R7 halted cleared", 32'(halted), 0);
        chk("R9 freeze_out cleared", 32'(freeze_out), 0);
        push(16'h7E57);
        chk("R7 resume pointer", 32'(wr_ptr), 32'(mptr));
        read_chk("R7 resumed word", mptr - 1);

        // R4/R9: shared-line trigger, zero post length
        post_len  = 8'd0;
        freeze_in = 1'b1;
        push(16'h6101);
        freeze_in = 1'b0;
        chk("R4 zero post halts", 32'(halted), 1);
        chk("R9 no echo of shared freeze", 32'(freeze_out), 0);
        chk("R8 pulse on shared trigger", 32'(err_trig), 1);
        repeat (4) step();
        chk("R8 pulse ended", 32'(err_trig), 0);
        local_err = 1'b1;
        in_valid  = 1'b1;
        in_data   = 16'hBAD0;
        step();
        local_err = 1'b0;
        in_valid  = 1'b0;
        step();
        chk("R8 no pulse while frozen", 32'(err_trig), 0);
        chk("R9 no freeze_out while frozen", 32'(freeze_out), 0);
        chk("R5 pointer held on halted write", 32'(wr_ptr), 32'(mptr));
        read_chk("R5 last word intact", mptr - 1);
        host_unfreeze = 1'b1;
        step();
        host_unfreeze = 1'b0;

        // R3: wrap
        while (mptr != DEPTH - 1) push(16'(mptr) ^ 16'h9C00);
        chk("R3 no wrap before last address", 32'(wrapped), 0);
        push(16'hF1F1);
        chk("R3 pointer wrapped to zero", 32'(wr_ptr), 0);
        chk("R3 wrap flag set", 32'(wrapped), 1);
        push(16'h0F0F);
        chk("R3 wrap flag sticky", 32'(wrapped), 1);
        read_chk("R3 last address word", DEPTH - 1);
        read_chk("R3 overwritten word", 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule